// File: doc/BRIEF.md
# Miss Entry with Primary and Deferred Target Queues

This block is one outstanding-miss slot of a non-blocking cache. When a miss is opened it latches the block address, the access size, an earliest-ready time and an order number, and it stores the first requester as a target. Later requesters to the same block are attached as further targets. Each one either rides on the request already sent downstream or waits in a second queue for a later re-request. Each target is a small tag made of a command code, a source, an order number and a pending mark.

Whether a target waits depends on the entry's coherence flags: in-service, pending-dirty, post-invalidate, post-downgrade and forward. When the primary queue drains while targets still wait, the two queues exchange roles without copying data, and the entry becomes ready to issue again. When a fill arrives exclusive and nothing has taken the block away, waiting targets that want ownership no longer need a second request. They are moved, one per cycle, to the tail of the primary queue.

Top module: `miss_entry`

## Requirements
- R1: With the entry free, `alloc_valid` captures address, size, ready time and order, clears in-service, pending-dirty and both post flags, and pushes one primary target with pend mark 1. Its source is 1 (prefetcher) when the command is 5 (prefetch) and 0 (CPU) otherwise. An allocate while busy is ignored.
- R2: An accepted target that is not deferred joins the primary queue tail. Its pend mark is 1 only if the entry is not yet in service.
- R3: A target is deferred (`add_deferred`=1) only while in service and when one of these holds: the deferred queue is non-empty; post-invalidate is set; or the command needs ownership and pending-dirty is clear, post-downgrade is set or the entry is a forward. Ownership commands are 1, 2, 3, 4, 6 and 8. Deferred targets carry pend mark 1.
- R4: A target deferred while post-invalidate is set is rewritten: upgrade (2) becomes read-exclusive (1), conditional-store upgrade (3) becomes upgrade-fail (6), and conditional store (4) becomes store-fail (7).
- R5: A pushed non-snoop target with an ownership command sets its queue's needs-ownership flag. Commands 2, 3 and 4 set its has-upgrade flag. Both flags are visible for the primary queue.
- R6: `svc_valid` on an allocated entry not in service sets in-service. It sets pending-dirty when the primary queue needs ownership or when `svc_mem_inhibit`=1 with `svc_shared`=0. It clears both post flags.
- R7: `total_targets` rises by one per accepted add and falls by one per pop. It always equals the sum of both queue counts.
- R8: On a cycle with no request input, an empty primary queue and a non-empty deferred queue, `promote` is 1. At the clock edge the roles swap, the entry order takes the new head's order, in-service and all coherence flags clear, and the old primary's flags clear.
- R9: A fill with `fill_shared`=0, no post flag set and a deferred queue that needs ownership sets the primary needs-ownership flag. All deferred targets then move in order to the primary tail with pend mark 0. Adds stall while this move runs. A shared fill changes nothing.
- R10: `dealloc_valid` frees the entry only when both queues are empty and the target count is zero. Otherwise it is ignored.
- R11: An add aimed at a full queue, at a free entry or during a move raises `add_stall` and is dropped.
- R12: `head_*` shows the oldest primary target, and `pop_valid` removes it, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Open the entry |
| alloc_addr | input | ADDR_W | Block address |
| alloc_size | input | SIZE_W | Access size |
| alloc_ready | input | TIME_W | Earliest ready time |
| alloc_order | input | ORD_W | Order number of first target |
| alloc_cmd | input | 4 | Command of first target |
| alloc_fwd | input | 1 | Entry is a forward |
| add_valid | input | 1 | Attach a target |
| add_cmd | input | 4 | Command of new target |
| add_order | input | ORD_W | Order number of new target |
| svc_valid | input | 1 | Request issued downstream |
| svc_mem_inhibit | input | 1 | Response path signals inhibit |
| svc_shared | input | 1 | Response path signals shared |
| post_inv_set | input | 1 | Snoop left a pending invalidate |
| post_down_set | input | 1 | Snoop left a pending downgrade |
| fill_valid | input | 1 | Fill response arrives |
| fill_shared | input | 1 | Fill is shared |
| pop_valid | input | 1 | Retire the primary head |
| dealloc_valid | input | 1 | Free the entry |
| busy | output | 1 | Entry allocated |
| in_service | output | 1 | Request outstanding downstream |
| pending_dirty | output | 1 | Ownership expected |
| post_inv | output | 1 | Pending invalidate |
| post_down | output | 1 | Pending downgrade |
| entry_addr | output | ADDR_W | Latched address |
| entry_size | output | SIZE_W | Latched size |
| entry_ready | output | TIME_W | Latched ready time |
| entry_order | output | ORD_W | Entry order number |
| head_valid | output | 1 | Primary queue non-empty |
| head_cmd | output | 4 | Head command |
| head_src | output | 2 | Head source |
| head_order | output | ORD_W | Head order number |
| head_pend | output | 1 | Head pend mark |
| prim_count | output | CNT_W | Primary occupancy |
| defer_count | output | CNT_W | Deferred occupancy |
| total_targets | output | TOT_W | Target count |
| prim_needs_excl | output | 1 | Primary needs-ownership flag |
| prim_has_upg | output | 1 | Primary has-upgrade flag |
| add_deferred | output | 1 | Current add goes to deferred queue |
| add_stall | output | 1 | Current add is dropped |
| promote | output | 1 | Role swap this cycle |
| merging | output | 1 | Deferred-to-primary move running |

## Verification
Targets are attached before issue, after a plain issue, after an issue that expects ownership, under pending invalidate, under pending downgrade and on a forward entry. Each pattern separates one arm of the deferral rule from the others. Rewrites are observed once the deferred queue has been promoted, which also shows that promotion keeps arrival order. Shared and exclusive fills over the same waiting targets separate the move from a no-op. Filling the deferred queue past its depth shows the drop and the unchanged count.

// File: rtl/miss_entry_pkg.sv
package miss_entry_pkg;

    localparam int ORD_W = 8;

    typedef enum logic [3:0] {
        MC_READ       = 4'd0,
        MC_READ_EX    = 4'd1,
        MC_UPGRADE    = 4'd2,
        MC_SC_UPGRADE = 4'd3,
        MC_STORE_COND = 4'd4,
        MC_PREFETCH   = 4'd5,
        MC_UPG_FAIL   = 4'd6,
        MC_SC_FAIL    = 4'd7,
        MC_WRITE      = 4'd8,
        MC_RSVD9      = 4'd9,
        MC_RSVD10     = 4'd10,
        MC_RSVD11     = 4'd11,
        MC_RSVD12     = 4'd12,
        MC_RSVD13     = 4'd13,
        MC_RSVD14     = 4'd14,
        MC_RSVD15     = 4'd15
    } mcmd_e;

    typedef enum logic [1:0] {
        SRC_CPU   = 2'd0,
        SRC_PREF  = 2'd1,
        SRC_SNOOP = 2'd2,
        SRC_RSVD  = 2'd3
    } msrc_e;

    typedef struct packed {
        mcmd_e             cmd;
        msrc_e             src;
        logic [ORD_W-1:0]  ord;
        logic              pend;
    } mtgt_t;

    function automatic logic cmd_needs_excl(input mcmd_e c);
        case (c)
            MC_READ_EX, MC_UPGRADE, MC_SC_UPGRADE,
            MC_STORE_COND, MC_UPG_FAIL, MC_WRITE: return 1'b1;
            default:                              return 1'b0;
        endcase
    endfunction

    function automatic logic cmd_is_upg(input mcmd_e c);
        return (c == MC_UPGRADE) || (c == MC_SC_UPGRADE) || (c == MC_STORE_COND);
    endfunction

    function automatic mcmd_e cmd_rewrite(input mcmd_e c);
        case (c)
            MC_UPGRADE:    return MC_READ_EX;
            MC_SC_UPGRADE: return MC_UPG_FAIL;
            MC_STORE_COND: return MC_SC_FAIL;
            default:       return c;
        endcase
    endfunction

endpackage

// File: rtl/miss_tgt_fifo.sv
module miss_tgt_fifo
    import miss_entry_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  mtgt_t            push_d,
    input  logic             pop,
    input  logic             flag_clr,
    input  logic             excl_force,
    output mtgt_t            head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             needs_excl,
    output logic             has_upg
);

    mtgt_t            slots [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             nx_q, upg_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wr_q] <= push_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flag_clr) begin
            nx_q  <= 1'b0;
            upg_q <= 1'b0;
        end else begin
            if (excl_force) nx_q <= 1'b1;
            if (push && push_d.src != SRC_SNOOP) begin
                if (cmd_needs_excl(push_d.cmd)) nx_q  <= 1'b1;
                if (cmd_is_upg(push_d.cmd))     upg_q <= 1'b1;
            end
        end
    end

    assign head       = slots[rd_q];
    assign count      = cnt_q;
    assign full       = (cnt_q == CNT_W'(DEPTH));
    assign empty      = (cnt_q == '0);
    assign needs_excl = nx_q;
    assign has_upg    = upg_q;

    // R11: the owner never pushes into a full queue
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R12: the owner never pops an empty queue
    p_no_underflow_r12: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/miss_defer_rule.sv
module miss_defer_rule
    import miss_entry_pkg::*;
(
    input  logic  in_svc,
    input  logic  defer_busy,
    input  logic  post_inv,
    input  logic  post_down,
    input  logic  pend_dirty,
    input  logic  is_fwd,
    input  mcmd_e cmd_in,
    output logic  to_defer,
    output mcmd_e cmd_out,
    output logic  pend_out
);

    logic excl_blocked;

    always_comb begin
        excl_blocked = cmd_needs_excl(cmd_in) && (!pend_dirty || post_down || is_fwd);
        to_defer     = in_svc && (defer_busy || post_inv || excl_blocked);
        cmd_out      = (to_defer && post_inv) ? cmd_rewrite(cmd_in) : cmd_in;
        pend_out     = to_defer ? 1'b1 : !in_svc;
    end

endmodule

// File: rtl/miss_entry.sv
module miss_entry
    import miss_entry_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int SIZE_W = 8,
    parameter  int TIME_W = 16,
    parameter  int DEPTH  = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int TOT_W  = $clog2(2 * DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [SIZE_W-1:0] alloc_size,
    input  logic [TIME_W-1:0] alloc_ready,
    input  logic [ORD_W-1:0]  alloc_order,
    input  logic [3:0]        alloc_cmd,
    input  logic              alloc_fwd,
    input  logic              add_valid,
    input  logic [3:0]        add_cmd,
    input  logic [ORD_W-1:0]  add_order,
    input  logic              svc_valid,
    input  logic              svc_mem_inhibit,
    input  logic              svc_shared,
    input  logic              post_inv_set,
    input  logic              post_down_set,
    input  logic              fill_valid,
    input  logic              fill_shared,
    input  logic              pop_valid,
    input  logic              dealloc_valid,
    output logic              busy,
    output logic              in_service,
    output logic              pending_dirty,
    output logic              post_inv,
    output logic              post_down,
    output logic [ADDR_W-1:0] entry_addr,
    output logic [SIZE_W-1:0] entry_size,
    output logic [TIME_W-1:0] entry_ready,
    output logic [ORD_W-1:0]  entry_order,
    output logic              head_valid,
    output logic [3:0]        head_cmd,
    output logic [1:0]        head_src,
    output logic [ORD_W-1:0]  head_order,
    output logic              head_pend,
    output logic [CNT_W-1:0]  prim_count,
    output logic [CNT_W-1:0]  defer_count,
    output logic [TOT_W-1:0]  total_targets,
    output logic              prim_needs_excl,
    output logic              prim_has_upg,
    output logic              add_deferred,
    output logic              add_stall,
    output logic              promote,
    output logic              merging
);

    logic              busy_q, in_svc_q, pdirty_q, pinv_q, pdown_q, fwd_q, sel_q, merging_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [TIME_W-1:0] ready_q;
    logic [ORD_W-1:0]  order_q;
    logic [TOT_W-1:0]  total_q;

    logic              q_push  [2];
    mtgt_t             q_pd    [2];
    logic              q_pop   [2];
    logic              q_clr   [2];
    logic              q_xf    [2];
    mtgt_t             q_head  [2];
    logic [CNT_W-1:0]  q_cnt   [2];
    logic              q_full  [2];
    logic              q_empty [2];
    logic              q_nx    [2];
    logic              q_upg   [2];

    logic  pri, dfr;
    logic  to_defer, add_pend;
    mcmd_e add_cmd_fix;
    logic  alloc_go, add_go, pop_go, svc_go, dealloc_go;
    logic  merge_start, merge_move, merge_done, promote_go, dest_full, any_req;
    mtgt_t alloc_tgt, add_tgt, move_tgt;

    assign pri = sel_q;
    assign dfr = ~sel_q;

    miss_defer_rule u_rule (
        .in_svc     (in_svc_q),
        .defer_busy (!q_empty[dfr]),
        .post_inv   (pinv_q),
        .post_down  (pdown_q),
        .pend_dirty (pdirty_q),
        .is_fwd     (fwd_q),
        .cmd_in     (mcmd_e'(add_cmd)),
        .to_defer   (to_defer),
        .cmd_out    (add_cmd_fix),
        .pend_out   (add_pend)
    );

    for (genvar g = 0; g < 2; g++) begin : g_queue
        miss_tgt_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push       (q_push[g]),
            .push_d     (q_pd[g]),
            .pop        (q_pop[g]),
            .flag_clr   (q_clr[g]),
            .excl_force (q_xf[g]),
            .head       (q_head[g]),
            .count      (q_cnt[g]),
            .full       (q_full[g]),
            .empty      (q_empty[g]),
            .needs_excl (q_nx[g]),
            .has_upg    (q_upg[g])
        );
    end

    always_comb begin
        any_req     = alloc_valid || add_valid || svc_valid || fill_valid || pop_valid;
        alloc_go    = alloc_valid && !busy_q;
        dest_full   = to_defer ? q_full[dfr] : q_full[pri];
        add_go      = add_valid && busy_q && !merging_q && !dest_full;
        pop_go      = pop_valid && busy_q && !q_empty[pri];
        svc_go      = svc_valid && busy_q && !in_svc_q;
        merge_start = fill_valid && busy_q && in_svc_q && !merging_q && !fill_shared
                      && !pinv_q && !pdown_q && q_nx[dfr] && !q_empty[dfr];
        merge_move  = merging_q && !q_empty[dfr] && !q_full[pri];
        merge_done  = merging_q && q_empty[dfr];
        promote_go  = busy_q && !merging_q && q_empty[pri] && !q_empty[dfr] && !any_req;
        dealloc_go  = dealloc_valid && busy_q && q_empty[0] && q_empty[1] && (total_q == '0);

        alloc_tgt.cmd  = mcmd_e'(alloc_cmd);
        alloc_tgt.src  = (mcmd_e'(alloc_cmd) == MC_PREFETCH) ? SRC_PREF : SRC_CPU;
        alloc_tgt.ord  = alloc_order;
        alloc_tgt.pend = 1'b1;

        add_tgt.cmd  = add_cmd_fix;
        add_tgt.src  = SRC_CPU;
        add_tgt.ord  = add_order;
        add_tgt.pend = add_pend;

        move_tgt      = q_head[dfr];
        move_tgt.pend = 1'b0;

        for (int p = 0; p < 2; p++) begin
            q_push[p] = (p[0] == pri) ? (alloc_go || (add_go && !to_defer) || merge_move)
                                      : (add_go && to_defer);
            q_pd[p]   = alloc_go ? alloc_tgt : (merge_move ? move_tgt : add_tgt);
            q_pop[p]  = (p[0] == pri) ? pop_go : merge_move;
            q_clr[p]  = dealloc_go || ((p[0] == pri) ? promote_go : merge_done);
            q_xf[p]   = (p[0] == pri) && merge_start;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            in_svc_q  <= 1'b0;
            pdirty_q  <= 1'b0;
            pinv_q    <= 1'b0;
            pdown_q   <= 1'b0;
            fwd_q     <= 1'b0;
            sel_q     <= 1'b0;
            merging_q <= 1'b0;
            addr_q    <= '0;
            size_q    <= '0;
            ready_q   <= '0;
            order_q   <= '0;
            total_q   <= '0;
        end else if (alloc_go) begin
            busy_q    <= 1'b1;
            in_svc_q  <= 1'b0;
            pdirty_q  <= 1'b0;
            pinv_q    <= 1'b0;
            pdown_q   <= 1'b0;
            fwd_q     <= alloc_fwd;
            merging_q <= 1'b0;
            addr_q    <= alloc_addr;
            size_q    <= alloc_size;
            ready_q   <= alloc_ready;
            order_q   <= alloc_order;
            total_q   <= TOT_W'(1);
        end else if (dealloc_go) begin
            busy_q    <= 1'b0;
            in_svc_q  <= 1'b0;
            pdirty_q  <= 1'b0;
            pinv_q    <= 1'b0;
            pdown_q   <= 1'b0;
            merging_q <= 1'b0;
        end else begin
            total_q <= total_q + TOT_W'(add_go) - TOT_W'(pop_go);
            if (svc_go) begin
                in_svc_q <= 1'b1;
                pdirty_q <= q_nx[pri] || (svc_mem_inhibit && !svc_shared);
                pinv_q   <= 1'b0;
                pdown_q  <= 1'b0;
            end else begin
                if (post_inv_set && busy_q && in_svc_q)  pinv_q  <= 1'b1;
                if (post_down_set && busy_q && in_svc_q) pdown_q <= 1'b1;
            end
            if (merge_start) merging_q <= 1'b1;
            if (merge_done)  merging_q <= 1'b0;
            if (promote_go) begin
                sel_q    <= ~sel_q;
                order_q  <= q_head[dfr].ord;
                in_svc_q <= 1'b0;
                pdirty_q <= 1'b0;
                pinv_q   <= 1'b0;
                pdown_q  <= 1'b0;
            end
        end
    end

    assign busy            = busy_q;
    assign in_service      = in_svc_q;
    assign pending_dirty   = pdirty_q;
    assign post_inv        = pinv_q;
    assign post_down       = pdown_q;
    assign entry_addr      = addr_q;
    assign entry_size      = size_q;
    assign entry_ready     = ready_q;
    assign entry_order     = order_q;
    assign head_valid      = !q_empty[pri];
    assign head_cmd        = q_head[pri].cmd;
    assign head_src        = q_head[pri].src;
    assign head_order      = q_head[pri].ord;
    assign head_pend       = q_head[pri].pend;
    assign prim_count      = q_cnt[pri];
    assign defer_count     = q_cnt[dfr];
    assign total_targets   = total_q;
    assign prim_needs_excl = q_nx[pri];
    assign prim_has_upg    = q_upg[pri];
    assign add_deferred    = add_go && to_defer;
    assign add_stall       = add_valid && !add_go;
    assign promote         = promote_go;
    assign merging         = merging_q;

    // R7: the target count tracks both queues together
    p_count_sum_r7: assert property (@(posedge clk) disable iff (rst)
        total_q == TOT_W'(q_cnt[0]) + TOT_W'(q_cnt[1]));

    // R3: targets wait only behind an issued request
    p_defer_needs_svc_r3: assert property (@(posedge clk) disable iff (rst)
        !in_svc_q |-> q_empty[dfr]);

    // R8: a swap leaves a filled primary queue ready to re-issue
    p_promote_r8: assert property (@(posedge clk) disable iff (rst)
        promote_go |=> (head_valid && !in_svc_q));

    // R9: during a move the primary queue already needs ownership
    p_merge_excl_r9: assert property (@(posedge clk) disable iff (rst)
        merging_q |-> q_nx[pri]);

    // R10: the entry is freed only with no target left
    p_dealloc_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(total_q) == '0));

    // R6: issuing starts with no snoop side effects recorded
    p_svc_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(in_svc_q) |-> (!pinv_q && !pdown_q));

endmodule

// File: tb/test_miss_entry.sv
module test_miss_entry;
    import miss_entry_pkg::*;

    localparam int ADDR_W = 32, SIZE_W = 8, TIME_W = 16, DEPTH = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int TOT_W = $clog2(2 * DEPTH + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic alloc_valid = 0, alloc_fwd = 0, add_valid = 0, svc_valid = 0;
    logic svc_mem_inhibit = 0, svc_shared = 0, post_inv_set = 0, post_down_set = 0;
    logic fill_valid = 0, fill_shared = 0, pop_valid = 0, dealloc_valid = 0;
    logic [ADDR_W-1:0] alloc_addr = '0;
    logic [SIZE_W-1:0] alloc_size = '0;
    logic [TIME_W-1:0] alloc_ready = '0;
    logic [ORD_W-1:0]  alloc_order = '0, add_order = '0;
    logic [3:0]        alloc_cmd = '0, add_cmd = '0;

    logic busy, in_service, pending_dirty, post_inv, post_down;
    logic [ADDR_W-1:0] entry_addr;
    logic [SIZE_W-1:0] entry_size;
    logic [TIME_W-1:0] entry_ready;
    logic [ORD_W-1:0]  entry_order, head_order;
    logic head_valid, head_pend, prim_needs_excl, prim_has_upg;
    logic [3:0] head_cmd;
    logic [1:0] head_src;
    logic [CNT_W-1:0] prim_count, defer_count;
    logic [TOT_W-1:0] total_targets;
    logic add_deferred, add_stall, promote, merging;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    miss_entry #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TIME_W(TIME_W), .DEPTH(DEPTH)) i_miss_entry (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_size(alloc_size),
        .alloc_ready(alloc_ready), .alloc_order(alloc_order), .alloc_cmd(alloc_cmd),
        .alloc_fwd(alloc_fwd), .add_valid(add_valid), .add_cmd(add_cmd), .add_order(add_order),
        .svc_valid(svc_valid), .svc_mem_inhibit(svc_mem_inhibit), .svc_shared(svc_shared),
        .post_inv_set(post_inv_set), .post_down_set(post_down_set),
        .fill_valid(fill_valid), .fill_shared(fill_shared), .pop_valid(pop_valid),
        .dealloc_valid(dealloc_valid), .busy(busy), .in_service(in_service),
        .pending_dirty(pending_dirty), .post_inv(post_inv), .post_down(post_down),
        .entry_addr(entry_addr), .entry_size(entry_size), .entry_ready(entry_ready),
        .entry_order(entry_order), .head_valid(head_valid), .head_cmd(head_cmd),
        .head_src(head_src), .head_order(head_order), .head_pend(head_pend),
        .prim_count(prim_count), .defer_count(defer_count), .total_targets(total_targets),
        .prim_needs_excl(prim_needs_excl), .prim_has_upg(prim_has_upg),
        .add_deferred(add_deferred), .add_stall(add_stall), .promote(promote),
        .merging(merging)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_alloc(input logic [3:0] c, input logic [ORD_W-1:0] o,
                            input logic [ADDR_W-1:0] a, input logic fwd);
        alloc_valid = 1; alloc_cmd = c; alloc_order = o; alloc_addr = a;
        alloc_size = 8'd64; alloc_ready = 16'd100; alloc_fwd = fwd;
        step();
        alloc_valid = 0; alloc_fwd = 0;
        #1;
    endtask

    task automatic do_add(input logic [3:0] c, input logic [ORD_W-1:0] o,
                          output logic d, output logic s);
        add_valid = 1; add_cmd = c; add_order = o;
        #1;
        d = add_deferred; s = add_stall;
        step();
        add_valid = 0;
        #1;
    endtask

    task automatic do_svc(input logic mi, input logic sh);
        svc_valid = 1; svc_mem_inhibit = mi; svc_shared = sh;
        step();
        svc_valid = 0; svc_mem_inhibit = 0; svc_shared = 0;
        #1;
    endtask

    task automatic do_pop();
        pop_valid = 1;
        step();
        pop_valid = 0;
        #1;
    endtask

    task automatic do_post(input logic inv, input logic down);
        post_inv_set = inv; post_down_set = down;
        step();
        post_inv_set = 0; post_down_set = 0;
        #1;
    endtask

    task automatic do_fill(input logic sh);
        fill_valid = 1; fill_shared = sh;
        step();
        fill_valid = 0; fill_shared = 0;
        #1;
    endtask

    task automatic drain_free();
        for (int k = 0; k < 16; k++) begin
            if (head_valid) do_pop();
            else step();
        end
        dealloc_valid = 1;
        step();
        dealloc_valid = 0;
        #1;
        chk("R10 freed when empty", busy, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset busy", busy, 0);
        chk("R7 reset total", total_targets, 0);
        chk("R12 reset head_valid", head_valid, 0);
        chk("R6 reset in_service", in_service, 0);
    endtask

    task automatic t_alloc();
        do_alloc(4'd0, 8'd7, 32'h1000, 0);
        chk("R1 busy", busy, 1);
        chk("R1 addr", entry_addr, 32'h1000);
        chk("R1 size", entry_size, 64);
        chk("R1 ready", entry_ready, 100);
        chk("R1 order", entry_order, 7);
        chk("R1 head order", head_order, 7);
        chk("R1 head src cpu", head_src, 0);
        chk("R1 head pend", head_pend, 1);
        chk("R7 total after alloc", total_targets, 1);
        do_alloc(4'd1, 8'd9, 32'h2000, 0);
        chk("R1 alloc while busy ignored addr", entry_addr, 32'h1000);
        chk("R1 alloc while busy ignored total", total_targets, 1);
        drain_free();
        do_alloc(4'd5, 8'd70, 32'h3000, 0);
        chk("R1 prefetch source", head_src, 1);
        dealloc_valid = 1;
        step();
        dealloc_valid = 0;
        #1;
        chk("R10 dealloc with target ignored", busy, 1);
        drain_free();
    endtask

    task automatic t_primary();
        logic d, s;
        do_alloc(4'd0, 8'd10, 32'h4000, 0);
        do_add(4'd0, 8'd11, d, s);
        chk("R2 add before service not deferred", d, 0);
        chk("R7 total two", total_targets, 2);
        chk("R12 head unchanged", head_order, 10);
        do_svc(0, 0);
        chk("R6 in_service", in_service, 1);
        chk("R6 pending_dirty clear", pending_dirty, 0);
        do_add(4'd0, 8'd12, d, s);
        chk("R2 read after service joins primary", d, 0);
        do_pop();
        chk("R12 second head", head_order, 11);
        chk("R2 pend before service", head_pend, 1);
        do_pop();
        chk("R12 third head", head_order, 12);
        chk("R2 pend after service", head_pend, 0);
        chk("R7 total after pops", total_targets, 1);
        drain_free();
    endtask

    task automatic t_defer_promote();
        logic d, s;
        do_alloc(4'd0, 8'd20, 32'h5000, 0);
        do_svc(0, 0);
        do_add(4'd1, 8'd21, d, s);
        chk("R3 excl without pending dirty deferred", d, 1);
        do_add(4'd0, 8'd22, d, s);
        chk("R3 behind non-empty deferred", d, 1);
        chk("R3 defer count", defer_count, 2);
        chk("R7 total three", total_targets, 3);
        do_pop();
        chk("R8 promote raised", promote, 1);
        step();
        chk("R8 new head order", head_order, 21);
        chk("R8 entry order", entry_order, 21);
        chk("R8 in_service cleared", in_service, 0);
        chk("R8 prim count", prim_count, 2);
        chk("R8 defer empty", defer_count, 0);
        chk("R8 deferred pend mark", head_pend, 1);
        do_pop();
        chk("R8 order kept", head_order, 22);
        drain_free();
    endtask

    task automatic t_rewrite_full();
        logic d, s;
        do_alloc(4'd1, 8'd30, 32'h6000, 0);
        chk("R5 primary needs excl", prim_needs_excl, 1);
        do_svc(0, 0);
        chk("R6 pending_dirty from queue", pending_dirty, 1);
        do_add(4'd1, 8'd31, d, s);
        chk("R3 excl with pending dirty joins", d, 0);
        do_post(1, 0);
        chk("R4 post_inv set", post_inv, 1);
        do_add(4'd2, 8'd32, d, s);
        chk("R3 post_inv defers", d, 1);
        do_add(4'd3, 8'd33, d, s);
        do_add(4'd4, 8'd34, d, s);
        do_add(4'd0, 8'd35, d, s);
        chk("R11 deferred full", defer_count, 4);
        do_add(4'd0, 8'd36, d, s);
        chk("R11 stall on full", s, 1);
        chk("R11 dropped total", total_targets, 6);
        do_pop();
        do_pop();
        step();
        chk("R4 upgrade rewritten", head_cmd, 1);
        chk("R4 order", head_order, 32);
        chk("R5 no upgrade flag after rewrite", prim_has_upg, 0);
        do_pop();
        chk("R4 sc upgrade rewritten", head_cmd, 6);
        do_pop();
        chk("R4 store cond rewritten", head_cmd, 7);
        do_pop();
        chk("R11 last kept order", head_order, 35);
        drain_free();
    endtask

    task automatic t_flags();
        logic d, s;
        do_alloc(4'd0, 8'd40, 32'h7000, 0);
        do_add(4'd2, 8'd41, d, s);
        chk("R5 has upgrade", prim_has_upg, 1);
        do_svc(1, 0);
        chk("R6 pending_dirty from inhibit", pending_dirty, 1);
        do_add(4'd8, 8'd42, d, s);
        chk("R3 write joins when dirty pending", d, 0);
        do_post(0, 1);
        do_add(4'd8, 8'd43, d, s);
        chk("R3 post_down defers excl", d, 1);
        drain_free();
        do_alloc(4'd0, 8'd50, 32'h8000, 1);
        do_svc(1, 1);
        chk("R6 shared inhibit no dirty", pending_dirty, 0);
        do_post(0, 1);
        do_svc(1, 0);
        chk("R6 second service ignored", pending_dirty, 0);
        drain_free();
        do_alloc(4'd0, 8'd52, 32'h8100, 1);
        do_svc(1, 0);
        do_add(4'd1, 8'd53, d, s);
        chk("R3 forward defers excl", d, 1);
        do_add(4'd0, 8'd54, d, s);
        chk("R2 add when free impossible check", s, 0);
        drain_free();
        do_add(4'd0, 8'd55, d, s);
        chk("R11 add to free entry stalls", s, 1);
    endtask

    task automatic t_merge();
        logic d, s;
        do_alloc(4'd0, 8'd60, 32'h9000, 0);
        do_svc(0, 0);
        do_add(4'd1, 8'd61, d, s);
        chk("R9 setup deferred", d, 1);
        do_fill(1);
        step(); step(); step();
        chk("R9 shared fill no move", defer_count, 1);
        chk("R9 shared fill no flag", prim_needs_excl, 0);
        do_fill(0);
        chk("R9 move running", merging, 1);
        do_add(4'd0, 8'd62, d, s);
        chk("R9 add stalls during move", s, 1);
        step(); step(); step();
        chk("R9 deferred emptied", defer_count, 0);
        chk("R9 primary grown", prim_count, 2);
        chk("R9 primary needs excl", prim_needs_excl, 1);
        chk("R9 still in service", in_service, 1);
        do_pop();
        chk("R9 moved order", head_order, 61);
        chk("R9 moved pend cleared", head_pend, 0);
        drain_free();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_alloc();
        t_primary();
        t_defer_promote();
        t_rewrite_full();
        t_flags();
        t_merge();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule